// File: doc/BRIEF.md
# Alternating-Clock Two-Wire Serial Receiver

This receiver listens to a two-wire bus where neither wire is a fixed clock. Both wires idle high. Each transfer opens with a lead-in: wire A is held low while wire B pulses, and then wire A rises. The number of pulses on B sets what the lead-in means. It can open a data packet, request the beam-detection mode, or order a bus reset. Inside a packet, the two wires take turns as clock. A bit is taken when the wire acting as clock falls, and the other wire carries the data.

Bits are packed into 32-bit words. The first byte received becomes the least significant byte, and each byte arrives most significant bit first. A closing sequence ends the packet. The last byte before it is an XOR checksum, and the receiver verifies it. Both inputs pass through synchroniser flops, and the block samples them at a rate well above the tightest edge spacing on the bus. The core is a four-state machine:

- `ST_IDLE`: waits for A to fall while B is high (transition IDLE→LEAD).
- `ST_LEAD`: counts falls on B. When A rises it either goes to `ST_BITS` (the data count) or returns to `ST_IDLE` (any other count, after emitting the beam or reset pulse where one applies).
- `ST_BITS`: samples bits. It goes to `ST_TAIL` when the closing marker is seen, and back to `ST_IDLE` on a both-high timeout.
- `ST_TAIL`: waits for B to rise with A high, then reports completion and returns to `ST_IDLE`. It also returns to `ST_IDLE` on timeout.

Top module: `duoline_rx`

## Requirements
- R1: After reset, every output strobe and flag is low, and the receiver waits for a lead-in.
- R2: If wire A rises after exactly DATA_PULSES (default 4) falling edges on wire B while A was low, a packet opens. All other counts open no packet.
- R3: A lead-in of exactly BEAM_PULSES (default 8) B falls gives a single-cycle `beam_seen_o` pulse when A rises.
- R4: A lead-in of exactly RESET_PULSES (default 14) B falls gives a single-cycle `reset_seen_o` pulse when A rises.
- R5: A lead-in with any other count, including zero, gives no output activity at all.
- R6: Wire A is the clock for the first bit of a packet, and the clock role swaps after every bit. A bit takes the level of the non-clock wire at the moment the clock wire falls.
- R7: Every 4 bytes produce one `word_valid_o` pulse with `word_o` = {byte3, byte2, byte1, byte0}, where byte0 is the first byte received. Within a byte, the first bit is bit 7.
- R8: A packet closes when two edges on B occur with A steady, at a point where A is the expected clock, and B later rises while A is high. The close gives a single-cycle `pkt_done_o` pulse.
- R9: `crc_err_o` is raised together with `pkt_done_o` in either of two cases: the XOR of all bytes, including the final checksum byte, is nonzero; or the byte count is not 4N+1 on a whole-byte boundary.
- R10: If both wires are high for more than TIMEOUT_CYC cycles inside a packet, the receiver gives a single-cycle `frame_err_o` pulse, abandons the packet, and gives no `pkt_done_o` for it.
- R11: A pause of any length inside a packet, with the wires not both high, neither aborts nor corrupts the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_a_i | input | 1 | Bus wire A (asynchronous) |
| line_b_i | input | 1 | Bus wire B (asynchronous) |
| word_o | output | 32 | Last assembled word |
| word_valid_o | output | 1 | One-cycle strobe: `word_o` is new |
| pkt_done_o | output | 1 | One-cycle strobe: packet closed |
| crc_err_o | output | 1 | Checksum or length error, valid with `pkt_done_o` |
| frame_err_o | output | 1 | One-cycle strobe: both-high timeout inside a packet |
| beam_seen_o | output | 1 | One-cycle strobe: beam-detection lead-in |
| reset_seen_o | output | 1 | One-cycle strobe: bus reset lead-in |

## Verification
Every result appears three clock edges after the wire edge that causes it: two synchroniser flops, then the registered output. That wire edge is the last A fall of a word, the final B rise of the closing sequence, or the A rise that ends a lead-in. The bench holds each bus phase for four cycles and waits eight cycles after each transaction before comparing. This puts every check after the due cycle and before any later stimulus. A monitor samples the strobes on the falling clock edge and counts them, so the checks compare the change in each count with the expected one. For the timeout case, the bench waits TIMEOUT_CYC plus a margin before checking.

// File: rtl/duoline_pkg.sv
package duoline_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BITS,
        ST_TAIL
    } rx_state_e;

    localparam int LINE_A = 0;
    localparam int LINE_B = 1;
endpackage

// File: rtl/duoline_sync.sv
module duoline_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], raw_i[g]};
        end
        assign lvl_o[g]  = pipe_q[STAGES-1];
        assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/duoline_packer.sv
module duoline_packer #(
    parameter int WORD_BYTES = 4,
    parameter int BYTE_BITS  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear_i,
    input  logic                            bit_valid_i,
    input  logic                            bit_i,
    output logic [WORD_BYTES*BYTE_BITS-1:0] word_o,
    output logic                            word_valid_o,
    output logic                            sum_zero_o,
    output logic                            one_spare_o
);
    localparam int WORD_W  = WORD_BYTES * BYTE_BITS;
    localparam int BIT_IW  = $clog2(BYTE_BITS);
    localparam int BYTE_IW = $clog2(WORD_BYTES);

    logic [BYTE_BITS-1:0] shift_q, new_byte, sum_q;
    logic [BIT_IW-1:0]    bit_idx_q;
    logic [BYTE_IW-1:0]   byte_idx_q;
    logic [WORD_W-1:0]    acc_q;
    logic                 byte_done;

    always_comb begin
        new_byte  = {shift_q[BYTE_BITS-2:0], bit_i};
        byte_done = bit_valid_i && (bit_idx_q == BIT_IW'(BYTE_BITS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q      <= '0;
            sum_q        <= '0;
            bit_idx_q    <= '0;
            byte_idx_q   <= '0;
            acc_q        <= '0;
            word_o       <= '0;
            word_valid_o <= 1'b0;
        end else begin
            word_valid_o <= 1'b0;
            if (clear_i) begin
                shift_q    <= '0;
                sum_q      <= '0;
                bit_idx_q  <= '0;
                byte_idx_q <= '0;
                acc_q      <= '0;
            end else if (bit_valid_i) begin
                shift_q <= new_byte;
                if (byte_done) begin
                    bit_idx_q <= '0;
                    sum_q     <= sum_q ^ new_byte;
                    acc_q[byte_idx_q*BYTE_BITS +: BYTE_BITS] <= new_byte;
                    if (byte_idx_q == BYTE_IW'(WORD_BYTES - 1)) begin
                        word_o       <= {new_byte, acc_q[WORD_W-BYTE_BITS-1:0]};
                        word_valid_o <= 1'b1;
                        byte_idx_q   <= '0;
                    end else begin
                        byte_idx_q <= byte_idx_q + 1'b1;
                    end
                end else begin
                    bit_idx_q <= bit_idx_q + 1'b1;
                end
            end
        end
    end

    assign sum_zero_o  = (sum_q == '0);
    assign one_spare_o = (byte_idx_q == BYTE_IW'(1)) && (bit_idx_q == '0);
endmodule

// File: rtl/duoline_watch.sv
module duoline_watch #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!run_i)               cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/duoline_rx.sv
module duoline_rx
    import duoline_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DATA_PULSES  = 4,
    parameter int BEAM_PULSES  = 8,
    parameter int RESET_PULSES = 14,
    parameter int TIMEOUT_CYC  = 1024,
    parameter int WORD_BYTES   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_a_i,
    input  logic                    line_b_i,
    output logic [WORD_BYTES*8-1:0] word_o,
    output logic                    word_valid_o,
    output logic                    pkt_done_o,
    output logic                    crc_err_o,
    output logic                    frame_err_o,
    output logic                    beam_seen_o,
    output logic                    reset_seen_o
);
    localparam int LEAD_MAX = RESET_PULSES + 1;
    localparam int LEAD_W   = $clog2(LEAD_MAX + 1);

    logic [1:0]        lvl, rise, fall;
    rx_state_e         state_q, state_d;
    logic [LEAD_W-1:0] lead_cnt_q;
    logic              clk_b_q;
    logic [1:0]        bedge_q;
    logic              a_hi, b_hi, a_edge, b_edge;
    logic              bit_take, bit_val, end_hit, lead_close, tail_close;
    logic              watch_run, expire, sum_zero, one_spare;

    duoline_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({line_b_i, line_a_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        a_hi       = lvl[LINE_A];
        b_hi       = lvl[LINE_B];
        a_edge     = rise[LINE_A] | fall[LINE_A];
        b_edge     = rise[LINE_B] | fall[LINE_B];
        bit_take   = (state_q == ST_BITS) && (clk_b_q ? fall[LINE_B] : fall[LINE_A]);
        bit_val    = clk_b_q ? a_hi : b_hi;
        end_hit    = (state_q == ST_BITS) && !clk_b_q && !a_edge && b_edge && (bedge_q == 2'd1);
        lead_close = (state_q == ST_LEAD) && rise[LINE_A];
        tail_close = (state_q == ST_TAIL) && rise[LINE_B] && a_hi;
        watch_run  = ((state_q == ST_BITS) || (state_q == ST_TAIL)) && a_hi && b_hi;
    end

    duoline_packer #(.WORD_BYTES(WORD_BYTES), .BYTE_BITS(8)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (lead_close),
        .bit_valid_i  (bit_take),
        .bit_i        (bit_val),
        .word_o       (word_o),
        .word_valid_o (word_valid_o),
        .sum_zero_o   (sum_zero),
        .one_spare_o  (one_spare)
    );

    duoline_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (watch_run),
        .expire_o (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fall[LINE_A] && b_hi) state_d = ST_LEAD;
            ST_LEAD: if (rise[LINE_A])
                         state_d = (lead_cnt_q == LEAD_W'(DATA_PULSES)) ? ST_BITS : ST_IDLE;
            ST_BITS: if (expire)       state_d = ST_IDLE;
                     else if (end_hit) state_d = ST_TAIL;
            ST_TAIL: if (expire || tail_close) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lead_cnt_q <= '0;
            clk_b_q    <= 1'b0;
            bedge_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_LEAD)
                lead_cnt_q <= '0;
            else if (fall[LINE_B] && lead_cnt_q != LEAD_W'(LEAD_MAX))
                lead_cnt_q <= lead_cnt_q + 1'b1;
            if (lead_close)    clk_b_q <= 1'b0;
            else if (bit_take) clk_b_q <= ~clk_b_q;
            if (state_q != ST_BITS || bit_take || a_edge)
                bedge_q <= '0;
            else if (b_edge && bedge_q != 2'd2)
                bedge_q <= bedge_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_done_o   <= 1'b0;
            crc_err_o    <= 1'b0;
            frame_err_o  <= 1'b0;
            beam_seen_o  <= 1'b0;
            reset_seen_o <= 1'b0;
        end else begin
            pkt_done_o   <= 1'b0;
            crc_err_o    <= 1'b0;
            frame_err_o  <= expire;
            beam_seen_o  <= lead_close && (lead_cnt_q == LEAD_W'(BEAM_PULSES));
            reset_seen_o <= lead_close && (lead_cnt_q == LEAD_W'(RESET_PULSES));
            if (tail_close && !expire) begin
                pkt_done_o <= 1'b1;
                crc_err_o  <= !(sum_zero && one_spare);
            end
        end
    end
endmodule

// File: rtl/duoline_rx_chk.sv
module duoline_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic word_valid_o,
    input logic pkt_done_o,
    input logic crc_err_o,
    input logic frame_err_o,
    input logic beam_seen_o,
    input logic reset_seen_o
);
    AST_CRC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_o |-> pkt_done_o); // R9
    AST_DONE_EXCLUDES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done_o && frame_err_o)); // R10
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o); // R10
    AST_BEAM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        beam_seen_o |=> !beam_seen_o); // R3
    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen_o |=> !reset_seen_o); // R4
    AST_LEAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beam_seen_o, reset_seen_o, pkt_done_o})); // R5
    AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done_o |=> !pkt_done_o); // R8
endmodule

bind duoline_rx duoline_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid_o (word_valid_o),
    .pkt_done_o   (pkt_done_o),
    .crc_err_o    (crc_err_o),
    .frame_err_o  (frame_err_o),
    .beam_seen_o  (beam_seen_o),
    .reset_seen_o (reset_seen_o)
);

// File: tb/duoline_rx_tb.sv
module duoline_rx_tb;
    localparam int CLK_NS = 10;
    localparam int PH     = 4;
    localparam int TMO    = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_r = 1'b1, b_r = 1'b1;
    logic [31:0] word;
    logic        word_valid, pkt_done, crc_err, frame_err, beam_seen, reset_seen;

    int n_chk = 0, n_err = 0;
    int n_words = 0, n_done = 0, n_frame = 0, n_beam = 0, n_rst = 0;
    logic        last_crc = 1'b0;
    logic [31:0] got [0:1023];
    logic [7:0]  pb [0:31];
    logic        clk_b = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    duoline_rx #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_a_i     (a_r),
        .line_b_i     (b_r),
        .word_o       (word),
        .word_valid_o (word_valid),
        .pkt_done_o   (pkt_done),
        .crc_err_o    (crc_err),
        .frame_err_o  (frame_err),
        .beam_seen_o  (beam_seen),
        .reset_seen_o (reset_seen)
    );

    always @(negedge clk) if (rst_n) begin
        if (word_valid) begin got[n_words % 1024] = word; n_words++; end
        if (pkt_done)   begin n_done++; last_crc = crc_err; end
        if (frame_err)  n_frame++;
        if (beam_seen)  n_beam++;
        if (reset_seen) n_rst++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic phase(input logic na, input logic nb);
        @(negedge clk);
        a_r = na;
        b_r = nb;
        repeat (PH - 1) @(negedge clk);
    endtask

    task automatic lead(input int n);
        phase(1'b0, 1'b1);
        for (int i = 0; i < n; i++) begin
            phase(1'b0, 1'b0);
            phase(1'b0, 1'b1);
        end
        phase(1'b1, 1'b1);
        clk_b = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        if (!clk_b) begin
            phase(1'b1, b_r); phase(1'b1, v); phase(1'b0, v);
        end else begin
            phase(a_r, 1'b1); phase(v, 1'b1); phase(v, 1'b0);
        end
        clk_b = ~clk_b;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_end();
        phase(1'b1, b_r); phase(1'b1, 1'b1); phase(1'b1, 1'b0);
        phase(1'b0, 1'b0); phase(1'b1, 1'b0); phase(1'b1, 1'b1);
    endtask

    function automatic logic [31:0] pack(input int w);
        return {pb[4*w+3], pb[4*w+2], pb[4*w+1], pb[4*w]};
    endfunction

    // bad: corrupt checksum; extra: append a zero byte; gap: long low pause after word 0
    task automatic packet(input int nw, input bit bad, input bit extra, input bit gap);
        logic [7:0] sum;
        int w0, d0, f0;
        sum = 8'h00;
        for (int i = 0; i < 4 * nw; i++) begin
            pb[i] = 8'($urandom);
            sum ^= pb[i];
        end
        if (bad) sum ^= 8'h5A;
        w0 = n_words; d0 = n_done; f0 = n_frame;
        lead(4);
        for (int i = 0; i < 4 * nw; i++) begin
            send_byte(pb[i]);
            if (gap && i == 3) repeat (3 * TMO) @(negedge clk);
        end
        send_byte(sum);
        if (extra) send_byte(8'h00);
        send_end();
        repeat (8) @(negedge clk);
        check(n_words - w0 == nw, "R7 word count", 32'(n_words - w0), 32'(nw));
        for (int w = 0; w < nw; w++)
            check(got[(w0 + w) % 1024] == pack(w), "R6/R7 word value", got[(w0 + w) % 1024], pack(w));
        check(n_done - d0 == 1, "R8 packet done", 32'(n_done - d0), 32'd1);
        check(last_crc == (bad || extra), "R9 crc flag", 32'(last_crc), 32'(bad || extra));
        check(n_frame == f0, gap ? "R11 no abort on gap" : "R2 no frame error", 32'(n_frame - f0), 32'd0);
    endtask

    task automatic probe(input int n);
        int b0, r0, w0, d0;
        b0 = n_beam; r0 = n_rst; w0 = n_words; d0 = n_done;
        lead(n);
        repeat (8) @(negedge clk);
        check(n_beam - b0 == int'(n == 8), "R3 beam pulse", 32'(n_beam - b0), 32'(n == 8));
        check(n_rst - r0 == int'(n == 14), "R4 reset pulse", 32'(n_rst - r0), 32'(n == 14));
        check((n_words == w0) && (n_done == d0), "R5 lead-in silent", 32'(n_words - w0 + n_done - d0), 32'd0);
    endtask

    task automatic timeout_case();
        int f0, d0;
        f0 = n_frame; d0 = n_done;
        lead(4);
        send_byte(8'($urandom));
        phase(1'b1, 1'b0);
        phase(1'b1, 1'b1);
        repeat (TMO + 20) @(negedge clk);
        check(n_frame - f0 == 1, "R10 frame error", 32'(n_frame - f0), 32'd1);
        check(n_done == d0, "R10 no done", 32'(n_done - d0), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check({word_valid, pkt_done, crc_err, frame_err, beam_seen, reset_seen} == 6'b0,
              "R1 reset outputs", 32'({word_valid, pkt_done, crc_err, frame_err, beam_seen, reset_seen}), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({word_valid, pkt_done, frame_err} == 3'b0, "R1 idle after reset", 32'({word_valid, pkt_done, frame_err}), 32'd0);
        packet(1, 1'b0, 1'b0, 1'b0);   // R2 R6 R7 R8
        packet(2, 1'b1, 1'b0, 1'b0);   // R9 bad checksum
        packet(1, 1'b0, 1'b1, 1'b0);   // R9 wrong length
        packet(5, 1'b0, 1'b0, 1'b1);   // R11 long pause
        probe(8);                      // R3
        probe(14);                     // R4
        probe(0);                      // R5
        probe(3);                      // R5
        timeout_case();                // R10
        packet(1, 1'b0, 1'b0, 1'b0);   // recovery after R10
        for (int k = 0; k < 12; k++) begin
            int n;
            packet(int'($urandom_range(1, 4)), ($urandom_range(0, 3) == 0), 1'b0, 1'b0);
            n = int'($urandom_range(0, 15));
            if (n == 4) n = 5;
            probe(n);
        end
        report();
        $finish;
    end
endmodule